// File: doc/BRIEF.md
# Autovectored Shared Interrupt Controller

This block merges fourteen FIFO and waveform-engine interrupt sources onto one shared processor interrupt line. Each source has a sticky pending bit that a one-cycle request pulse sets and a write-one-to-clear strobe resets. A fixed-priority encoder picks the most urgent source that is both pending and enabled and turns its position into a vector byte.

The processor takes the shared interrupt by fetching a jump instruction at 0x0053. The jump target's high byte sits in memory at 0x0054. When autovectoring is on, the block replaces the byte fetched from 0x0055 with the vector. A single jump instruction therefore lands on the handler for the winning source inside a 256-byte jump table.

The fetch interface is a plain control interface with no back-pressure. The processor pulses `fetch_start` with the address. Memory data passes through to `code_data`, except when a substitution is active. A substitution stays active from the clock edge that starts a 0x0055 fetch until the next `fetch_start` edge.

Top module: `sirq_autovec_ctrl`

## Requirements
- R1: A high `src_req[i]` at a clock edge sets pending bit i. The bit stays set on later cycles with no request until it is cleared.
- R2: A high `src_clr[i]` at a clock edge clears pending bit i. If `src_req[i]` and `src_clr[i]` are both high at the same edge, the bit ends up set.
- R3: `irq` is high exactly when `glob_en` is 1 and at least one source is both pending and enabled through `src_en`. It follows the pending bits and enables in the same cycle.
- R4: Priority is fixed by bit index, and index 0 is the highest. Bits 0 to 3 are the programmable-level flags of endpoints 2, 4, 6 and 8. Bits 4 to 7 are their empty flags. Bits 8 to 11 are their full flags. Bit 12 is waveform-done and bit 13 is waveform-event.
- R5: `vec_out` equals 0x80 + 4*i, where i is the lowest index that is pending and enabled. This gives values from 0x80 to 0xB4.
- R6: When no source is both pending and enabled, `vec_out` is 0x80.
- R7: A fetch of 0x0055 that starts while `av_en` is 1 and a source is pending and enabled makes `code_data` equal the vector captured at that start edge. This holds from the next cycle until the next `fetch_start` edge.
- R8: A 0x0055 fetch that starts while `av_en` is 0 returns `mem_data` unchanged.
- R9: Fetches of any address other than 0x0055, including 0x0053 and 0x0054, return `mem_data` unchanged.
- R10: A higher-priority source that becomes pending after a 0x0055 fetch has started does not change the substituted byte.
- R11: A 0x0055 fetch that starts with nothing pending and enabled returns `mem_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 14 | Per-source request pulses |
| src_en | input | 14 | Per-source enables |
| src_clr | input | 14 | Per-source write-one-to-clear strobes |
| glob_en | input | 1 | Global enable for the shared interrupt |
| av_en | input | 1 | Autovector enable bit |
| fetch_start | input | 1 | Pulse marking the start of a code fetch |
| fetch_addr | input | 16 | Code fetch address, valid with fetch_start |
| mem_data | input | 8 | Byte returned by code memory |
| irq | output | 1 | Shared interrupt request |
| vec_out | output | 8 | Vector of the highest-priority pending enabled source |
| code_data | output | 8 | Fetch data, possibly substituted with the vector |

## Verification
A request or clear shows in the pending state after the clock edge that samples it. `irq` and `vec_out` then follow combinationally, including any change to `src_en` or `glob_en` in the same cycle. Substitution on `code_data` starts in the cycle after the edge that samples a 0x0055 `fetch_start`. The bench drives inputs at the falling edge, checks all three outputs 1 ns later against a model updated at each rising edge, and so samples every result in the cycle it is due.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int          NSRC      = 14;
  localparam int          ADDR_W    = 16;
  localparam logic [7:0]  VEC_BASE  = 8'h80;
  localparam int          VEC_STEP  = 4;
  localparam logic [15:0] JUMP_ADDR = 16'h0053;
  // byte after opcode and page byte carries the table index
  localparam logic [15:0] VEC_ADDR  = JUMP_ADDR + 16'd2;
endpackage

// File: rtl/sirq_pending.sv
module sirq_pending #(
  parameter int N = sirq_pkg::NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend[g] <= 1'b0;
        else        pend[g] <= (pend[g] & ~clr[g]) | req[g];
      end

      // R1
      req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[g] |=> pend[g]);
      // R2
      clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[g] && !req[g]) |=> !pend[g]);
      // R1
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[g] && !clr[g]) |=> pend[g]);
    end
  endgenerate
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio #(
  parameter int         N    = sirq_pkg::NSRC,
  parameter logic [7:0] BASE = sirq_pkg::VEC_BASE,
  parameter int         STEP = sirq_pkg::VEC_STEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] act,
  output logic         hit,
  output logic [N-1:0] grant,
  output logic [7:0]   vec
);
  always_comb begin
    grant = '0;
    vec   = BASE;
    hit   = |act;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        vec      = BASE + 8'(i * STEP);
      end
    end
  end

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R5
  grant_in_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((grant & act) == grant) && (grant != '0));
  // R6
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (vec == BASE));
endmodule

// File: rtl/sirq_fetch_sub.sv
module sirq_fetch_sub #(
  parameter int               AW    = sirq_pkg::ADDR_W,
  parameter logic [AW-1:0]    VADDR = AW'(sirq_pkg::VEC_ADDR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_start,
  input  logic [AW-1:0] fetch_addr,
  input  logic          av_en,
  input  logic          hit,
  input  logic [7:0]    vec_in,
  input  logic [7:0]    mem_data,
  output logic [7:0]    code_data
);
  logic       sub_on;
  logic [7:0] vec_q;
  logic       vec_fetch;

  assign vec_fetch = fetch_start && (fetch_addr == VADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_on <= 1'b0;
      vec_q  <= 8'h00;
    end else if (fetch_start) begin
      sub_on <= vec_fetch && av_en && hit;
      if (vec_fetch) vec_q <= vec_in;
    end
  end

  assign code_data = sub_on ? vec_q : mem_data;

  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_on && !fetch_start) |=> $stable(vec_q));
  // R8
  av_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && !av_en) |=> (code_data == mem_data));
  // R9
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && fetch_addr != VADDR) |=> (code_data == mem_data));
  // R11
  none_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && !hit) |=> (code_data == mem_data));
endmodule

// File: rtl/sirq_autovec_ctrl.sv
module sirq_autovec_ctrl
  import sirq_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_req,
  input  logic [N-1:0]  src_en,
  input  logic [N-1:0]  src_clr,
  input  logic          glob_en,
  input  logic          av_en,
  input  logic          fetch_start,
  input  logic [AW-1:0] fetch_addr,
  input  logic [7:0]    mem_data,
  output logic          irq,
  output logic [7:0]    vec_out,
  output logic [7:0]    code_data
);
  logic [N-1:0] pend;
  logic [N-1:0] active;
  logic [N-1:0] grant;
  logic         hit;

  sirq_pending #(.N(N)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (src_req),
    .clr  (src_clr),
    .pend (pend)
  );

  assign active = pend & src_en;

  sirq_prio #(.N(N), .BASE(VEC_BASE), .STEP(VEC_STEP)) u_prio (
    .clk  (clk),
    .rst_n(rst_n),
    .act  (active),
    .hit  (hit),
    .grant(grant),
    .vec  (vec_out)
  );

  assign irq = glob_en & hit;

  sirq_fetch_sub #(.AW(AW), .VADDR(AW'(VEC_ADDR))) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_start(fetch_start),
    .fetch_addr (fetch_addr),
    .av_en      (av_en),
    .hit        (hit),
    .vec_in     (vec_out),
    .mem_data   (mem_data),
    .code_data  (code_data)
  );

  // R3
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);
  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((grant & pend & src_en) != '0));
endmodule

// File: tb/tb_sirq_autovec_ctrl.sv
module tb_sirq_autovec_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_req = '0, src_en = '0, src_clr = '0;
  logic        glob_en = 1'b0, av_en = 1'b0, fetch_start = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [7:0]  mem_data = '0;
  logic        irq;
  logic [7:0]  vec_out, code_data;

  int checks = 0;
  int failures = 0;

  logic [13:0] m_pend = '0;
  logic        m_sub = 1'b0;
  logic [7:0]  m_vq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sirq_autovec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .src_clr(src_clr), .glob_en(glob_en), .av_en(av_en),
    .fetch_start(fetch_start), .fetch_addr(fetch_addr), .mem_data(mem_data),
    .irq(irq), .vec_out(vec_out), .code_data(code_data)
  );

  function automatic logic [7:0] f_vec(input logic [13:0] a);
    f_vec = 8'h80;
    for (int i = 13; i >= 0; i--) if (a[i]) f_vec = 8'h80 + 8'(4 * i);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  // inputs already driven; checks, one edge, then pulses dropped
  task automatic run(input string tag);
    logic [13:0] act;
    #1;
    act = m_pend & src_en;
    chk(tag, "irq", {7'd0, irq}, {7'd0, glob_en & (|act)});
    chk(tag, "vec_out", vec_out, f_vec(act));
    chk(tag, "code_data", code_data, m_sub ? m_vq : mem_data);
    @(posedge clk);
    if (fetch_start) begin
      m_sub = (fetch_addr == 16'h0055) && av_en && (|act);
      if (fetch_addr == 16'h0055) m_vq = f_vec(act);
    end
    m_pend = (m_pend & ~src_clr) | src_req;
    @(negedge clk);
    src_req = '0; src_clr = '0; fetch_start = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] a, input logic [7:0] d);
    fetch_start = 1'b1; fetch_addr = a; mem_data = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk("R3", "reset irq", {7'd0, irq}, 8'd0);
    chk("R6", "reset vec", vec_out, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    glob_en = 1'b1; av_en = 1'b1; src_en = '1; mem_data = 8'h5A;
    run("R6");

    // R4 R5: each source alone
    for (int i = 0; i < 14; i++) begin
      src_req = 14'(1) << i; run("R1");
      chk("R5", "single vec", vec_out, 8'h80 + 8'(4 * i));
      src_clr = 14'(1) << i; run("R2");
    end
    // R4: two sources, lower index wins
    src_req = 14'h2080; run("R4");
    chk("R4", "pair vec", vec_out, 8'h9C);
    // R2: set and clear together
    src_req = 14'h0080; src_clr = 14'h0080; run("R2");
    chk("R2", "set wins", vec_out, 8'h9C);
    // R1 sticky over idle cycles
    run("R1"); run("R1");
    src_clr = 14'h3FFF; run("R2");
    // R11 fetch with nothing pending
    fetch(16'h0055, 8'h11); run("R11");
    chk("R11", "no pend data", code_data, 8'h11);
    // R7 substitution, R10 late higher source
    src_req = 14'h0020; run("R1");
    fetch(16'h0055, 8'h22); run("R7");
    chk("R7", "subst", code_data, 8'h94);
    src_req = 14'h0001; run("R10");
    chk("R10", "held vec", code_data, 8'h94);
    chk("R10", "new vec_out", vec_out, 8'h80);
    // R9 other addresses
    fetch(16'h0053, 8'h02); run("R9");
    chk("R9", "0x53 data", code_data, 8'h02);
    fetch(16'h0054, 8'h3C); run("R9");
    chk("R9", "0x54 data", code_data, 8'h3C);
    // R8 autovector disabled
    av_en = 1'b0; fetch(16'h0055, 8'h77); run("R8");
    chk("R8", "av off data", code_data, 8'h77);
    av_en = 1'b1;
    // R3 gating
    glob_en = 1'b0; #1;
    chk("R3", "glob off", {7'd0, irq}, 8'd0);
    glob_en = 1'b1; src_en = 14'h3FFE; #1;
    chk("R3", "masked src", {7'd0, irq}, 8'd1);
    chk("R5", "masked vec", vec_out, 8'h94);
    run("R3");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 14; b++) begin
        src_req[b] = ($urandom % 10) == 0;
        src_clr[b] = ($urandom % 6) == 0;
        src_en[b]  = ($urandom % 5) != 0;
      end
      glob_en = ($urandom % 8) != 0;
      av_en = ($urandom % 4) != 0;
      fetch_start = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: fetch_addr = 16'h0053;
        1: fetch_addr = 16'h0054;
        2: fetch_addr = 16'h0055;
        default: fetch_addr = 16'($urandom);
      endcase
      mem_data = 8'($urandom);
      run("R3/R5/R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule